// File: doc/BRIEF.md
# SD Card Clock Control Unit

This unit derives the clock sent to an MMC/SD card from the host's functional clock, which is nominally 96 MHz. Software programs a single control word through a write port. The word holds an internal-clock enable, a card-clock enable, a 10-bit divisor and a 4-bit data-timeout exponent. The same word can also request self-clearing soft resets of the command path and the data path. The unit returns the current state of the word on a read port, together with a read-only flag that reports when the internal clock is stable.

The card clock is released only after a fixed handshake. First the internal clock is enabled. The stable flag then rises a fixed number of cycles later. Only after that does the card-clock enable take effect. A divisor written while the card clock is running is kept pending and is applied only once the card clock has been stopped, so the output never changes rate mid-stream.

An initialization-stream request makes the unit count a fixed run of card-clock rising edges and then pulse a completion flag. This run is the dummy clocking a card expects before its first command.

Top module: `sdclk_ctrl`

## Requirements
- R1: After reset the read word is all zero, the card clock is low, both soft-reset outputs are low, and the busy and done flags of the initialization stream are low.
- R2: A write stores the internal-clock enable from bit 0, the card-clock enable from bit 2, the divisor from bits 15:6 and the timeout exponent from bits 19:16. All four read back at the same positions, and the exponent is also driven on `dto_exp`. Bit 1 of a write is ignored.
- R3: Read bit 1 (stable) becomes 1 exactly STABLE_CYCLES cycles after the write that sets the internal-clock enable. It reads 0 in the cycle right after a write that clears that enable.
- R4: The card clock stays low whenever the card-clock enable is 0, the internal-clock enable is 0, or the stable flag is still 0.
- R5: For a divisor N of 2 or more, the card clock has a period of N functional-clock cycles. It is high for ceil(N/2) of those cycles and low for floor(N/2).
- R6: A divisor of 0 or 1 passes the functional clock through to the card unchanged while the card clock is enabled.
- R7: A divisor written while the card-clock enable is 1 reads back at once but does not change the output rate. It is applied once the card-clock enable has been cleared.
- R8: Writing 1 to bit 25 raises `cmd_srst`, and writing 1 to bit 26 raises `dat_srst`. Each reads back at its own bit and stays high for exactly RST_CYCLES cycles before clearing itself. Writing 0 to a bit that is active does not cut it short.
- R9: A pulse on `init_go` sets `init_busy`. After INIT_CLKS card-clock rising edges, `init_done` is high for one cycle and `init_busy` falls in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fun | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word to write |
| init_go | input | 1 | Starts an initialization clock run |
| rd_data | output | 32 | Current control and status word |
| card_clk | output | 1 | Clock to the card |
| dto_exp | output | 4 | Data-timeout exponent |
| cmd_srst | output | 1 | Command-path soft reset |
| dat_srst | output | 1 | Data-path soft reset |
| init_busy | output | 1 | Initialization run in progress |
| init_done | output | 1 | One-cycle completion flag of the run |

## Verification
A write lands on the rising edge on which `wr_en` is sampled. Read-back bits, the soft-reset outputs and the gating of the card clock therefore change in the cycle after that edge. The stable flag follows STABLE_CYCLES edges later, and the divided clock's first high phase starts one edge after the card clock is enabled. The bench drives and samples on falling edges and counts these offsets cycle by cycle. Phase lengths are measured from the second rising edge onward, so the start-up latency stays out of the ratio check. The bypass path is sampled one nanosecond after each rising edge and again on the falling edge, because that output follows the functional clock itself.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;
  localparam int REG_W     = 32;
  localparam int BIT_ICE   = 0;
  localparam int BIT_STB   = 1;
  localparam int BIT_CEN   = 2;
  localparam int DIV_LSB   = 6;
  localparam int DIV_W     = 10;
  localparam int DTO_LSB   = 16;
  localparam int DTO_W     = 4;
  localparam int BIT_CRST  = 25;
  localparam int BIT_DRST  = 26;
  localparam int NUM_SRST  = 2;

  typedef struct packed {
    logic             ice;
    logic             cen;
    logic [DIV_W-1:0] div;
    logic [DTO_W-1:0] dto;
  } ctl_t;
endpackage

// File: rtl/sdclk_rst_sync.sv
module sdclk_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sdclk_regs.sv
module sdclk_regs
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int RST_CYCLES    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_data,
  output ctl_t              ctl,
  output logic              stable,
  output logic [NUM_SRST-1:0] srst,
  output logic [REG_W-1:0]  rd_data
);
  localparam int STB_W = $clog2(STABLE_CYCLES + 1);
  localparam int RST_W = $clog2(RST_CYCLES + 1);

  ctl_t ctl_q, ctl_d;
  logic [STB_W-1:0] stb_q, stb_d;

  // control word
  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) begin
      ctl_d.ice = wr_data[BIT_ICE];
      ctl_d.cen = wr_data[BIT_CEN];
      ctl_d.div = wr_data[DIV_LSB +: DIV_W];
      ctl_d.dto = wr_data[DTO_LSB +: DTO_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  // stability counter for the internal clock
  always_comb begin
    if (!ctl_q.ice)                         stb_d = '0;
    else if (stb_q == STB_W'(STABLE_CYCLES)) stb_d = stb_q;
    else                                    stb_d = stb_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= '0;
    else        stb_q <= stb_d;
  end

  assign stable = ctl_q.ice && (stb_q == STB_W'(STABLE_CYCLES));

  // self-clearing soft resets
  for (genvar g = 0; g < NUM_SRST; g++) begin : g_srst
    localparam int IDX = (g == 0) ? BIT_CRST : BIT_DRST;
    logic             act_q, act_d;
    logic [RST_W-1:0] cnt_q, cnt_d;

    always_comb begin
      act_d = act_q;
      cnt_d = cnt_q;
      if (wr_en && wr_data[IDX]) begin
        act_d = 1'b1;
        cnt_d = '0;
      end else if (act_q) begin
        if (cnt_q == RST_W'(RST_CYCLES - 1)) begin
          act_d = 1'b0;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        act_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        act_q <= act_d;
        cnt_q <= cnt_d;
      end
    end

    assign srst[g] = act_q;
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[BIT_ICE]            = ctl_q.ice;
    rd_data[BIT_STB]            = stable;
    rd_data[BIT_CEN]            = ctl_q.cen;
    rd_data[DIV_LSB +: DIV_W]   = ctl_q.div;
    rd_data[DTO_LSB +: DTO_W]   = ctl_q.dto;
    rd_data[BIT_CRST]           = srst[0];
    rd_data[BIT_DRST]           = srst[1];
  end

  assign ctl = ctl_q;

  logic unused_wr;
  assign unused_wr = ^{wr_data[31:27], wr_data[24:20], wr_data[5:3], wr_data[1]};
endmodule

// File: rtl/sdclk_icg.sv
module sdclk_icg (
  input  logic clk,
  input  logic en,
  output logic gclk
);
  logic en_lat;

  always_latch begin
    if (!clk) en_lat = en;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/sdclk_div.sv
module sdclk_div
  import sdclk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cen,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             card_clk,
  output logic             rise_tick
);
  logic [DIV_W-1:0] act_q, act_d;
  logic [DIV_W-1:0] ph_q, ph_d;
  logic [DIV_W-1:0] hi_len;
  logic             clk_q, clk_d;
  logic             bypass;
  logic             gclk;

  // divisor is only taken over while the card clock is disabled
  always_comb begin
    act_d = cen ? act_q : div_cfg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= '0;
    else        act_q <= act_d;
  end

  assign bypass = (act_q <= DIV_W'(1));
  assign hi_len = act_q - (act_q >> 1);

  always_comb begin
    if (!run || bypass) begin
      ph_d  = '0;
      clk_d = 1'b0;
    end else begin
      ph_d  = (ph_q == act_q - 1'b1) ? '0 : ph_q + 1'b1;
      clk_d = (ph_q < hi_len);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      clk_q <= 1'b0;
    end else begin
      ph_q  <= ph_d;
      clk_q <= clk_d;
    end
  end

  sdclk_icg u_icg (
    .clk  (clk),
    .en   (run & bypass),
    .gclk (gclk)
  );

  assign card_clk  = bypass ? gclk : (clk_q & run);
  assign rise_tick = run && (bypass || (ph_q == '0));
endmodule

// File: rtl/sdclk_init.sv
module sdclk_init #(
  parameter int INIT_CLKS = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic tick,
  output logic busy,
  output logic done
);
  localparam int CNT_W = $clog2(INIT_CLKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        cnt_d  = CNT_W'(INIT_CLKS);
      end
    end else if (tick) begin
      if (cnt_q == CNT_W'(1)) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/sdclk_ctrl.sv
module sdclk_ctrl
  import sdclk_pkg::*;
#(
  parameter int STABLE_CYCLES = 8,
  parameter int RST_CYCLES    = 4,
  parameter int INIT_CLKS     = 80
) (
  input  logic        clk_fun,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        init_go,
  output logic [31:0] rd_data,
  output logic        card_clk,
  output logic [3:0]  dto_exp,
  output logic        cmd_srst,
  output logic        dat_srst,
  output logic        init_busy,
  output logic        init_done
);
  logic                rst_sync_n;
  ctl_t                ctl;
  logic                stable;
  logic [NUM_SRST-1:0] srst;
  logic                run;
  logic                tick;

  sdclk_rst_sync u_rst (
    .clk        (clk_fun),
    .rst_n      (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  sdclk_regs #(
    .STABLE_CYCLES (STABLE_CYCLES),
    .RST_CYCLES    (RST_CYCLES)
  ) u_regs (
    .clk     (clk_fun),
    .rst_n   (rst_sync_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .ctl     (ctl),
    .stable  (stable),
    .srst    (srst),
    .rd_data (rd_data)
  );

  assign run = ctl.cen && stable;

  sdclk_div u_div (
    .clk       (clk_fun),
    .rst_n     (rst_sync_n),
    .run       (run),
    .cen       (ctl.cen),
    .div_cfg   (ctl.div),
    .card_clk  (card_clk),
    .rise_tick (tick)
  );

  sdclk_init #(
    .INIT_CLKS (INIT_CLKS)
  ) u_init (
    .clk   (clk_fun),
    .rst_n (rst_sync_n),
    .go    (init_go),
    .tick  (tick),
    .busy  (init_busy),
    .done  (init_done)
  );

  assign dto_exp  = ctl.dto;
  assign cmd_srst = srst[0];
  assign dat_srst = srst[1];
endmodule

// File: rtl/sdclk_ctrl_chk.sv
module sdclk_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [31:0] wr_data,
  input logic [31:0] rd_data,
  input logic        card_clk,
  input logic [3:0]  dto_exp,
  input logic        cmd_srst,
  input logic        dat_srst,
  input logic        init_busy,
  input logic        init_done
);
  assert_dto_written_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (dto_exp == $past(wr_data[19:16])));

  assert_stable_needs_ice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[1] |-> rd_data[0]);

  assert_stable_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[0]) |=> !rd_data[1]);

  assert_gate_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_data[0] && rd_data[2] && rd_data[1]) |-> !card_clk);

  assert_srst_mirror_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[25] == cmd_srst) && (rd_data[26] == dat_srst));

  assert_srst_no_early_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_srst) |-> !$past(wr_en && wr_data[25]));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> !init_done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> !init_busy);
endmodule

bind sdclk_ctrl sdclk_ctrl_chk u_chk (
  .clk       (clk_fun),
  .rst_n     (rst_sync_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .card_clk  (card_clk),
  .dto_exp   (dto_exp),
  .cmd_srst  (cmd_srst),
  .dat_srst  (dat_srst),
  .init_busy (init_busy),
  .init_done (init_done)
);

// File: tb/test_sdclk_ctrl.sv
`timescale 1ns/1ps
module test_sdclk_ctrl;
  localparam int STB   = 8;
  localparam int RSTC  = 4;
  localparam int INITC = 80;
  localparam int LIMIT = 200000;
  localparam int NV    = 6;
  // divisor, expected high cycles, expected low cycles
  localparam logic [29:0] VEC [NV] = '{
    {10'd2,  10'd1, 10'd1},
    {10'd3,  10'd2, 10'd1},
    {10'd4,  10'd2, 10'd2},
    {10'd5,  10'd3, 10'd2},
    {10'd7,  10'd4, 10'd3},
    {10'd10, 10'd5, 10'd5}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic        init_go;
  logic [31:0] rd_data;
  logic        card_clk;
  logic [3:0]  dto_exp;
  logic        cmd_srst, dat_srst, init_busy, init_done;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  sdclk_ctrl #(.STABLE_CYCLES(STB), .RST_CYCLES(RSTC), .INIT_CLKS(INITC)) i_sdclk_ctrl (
    .clk_fun (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
    .init_go (init_go), .rd_data (rd_data), .card_clk (card_clk),
    .dto_exp (dto_exp), .cmd_srst (cmd_srst), .dat_srst (dat_srst),
    .init_busy (init_busy), .init_done (init_done)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc >= LIMIT) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<%0d", cyc, LIMIT);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic ice, input logic cen, input logic [9:0] dv);
    mk = (32'(ice) << 0) | (32'(cen) << 2) | (32'(dv) << 6) | (32'hE << 16);
  endfunction

  // called on a falling edge; returns on the falling edge after the write lands
  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic measure(output int hi, output int lo);
    int guard = 0;
    hi = 0; lo = 0;
    while (card_clk !== 1'b0 && guard < 200) begin @(negedge clk); guard++; end
    while (card_clk !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
    while (card_clk === 1'b1 && guard < 200) begin hi++; @(negedge clk); guard++; end
    while (card_clk === 1'b0 && guard < 200) begin lo++; @(negedge clk); guard++; end
  endtask

  initial begin
    int hi, lo, n, rises;
    logic prev, seen_done;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0; init_go = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 rd_data", rd_data, 32'h0);
    chk("R1 card_clk", {31'd0, card_clk}, 32'd0);
    chk("R1 outputs", {28'd0, cmd_srst, dat_srst, init_busy, init_done}, 32'd0);

    // R2 field readback, bit 1 ignored
    wr(mk(1'b1, 1'b0, 10'd341) | 32'h2);
    chk("R2 readback", rd_data, mk(1'b1, 1'b0, 10'd341));
    chk("R2 dto_exp", {28'd0, dto_exp}, 32'hE);

    // R3 stability delay
    repeat (STB - 1) @(negedge clk);
    chk("R3 not yet stable", {31'd0, rd_data[1]}, 32'd0);
    @(negedge clk);
    chk("R3 stable", {31'd0, rd_data[1]}, 32'd1);

    // R4 card-clock enable off
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (card_clk !== 1'b0) n++; end
    chk("R4 cen=0 low", n, 0);

    // R5 divisor table
    for (int i = 0; i < NV; i++) begin
      wr(mk(1'b1, 1'b0, VEC[i][29:20]));
      wr(mk(1'b1, 1'b1, VEC[i][29:20]));
      measure(hi, lo);
      chk($sformatf("R5 high div=%0d", VEC[i][29:20]), hi, 32'(VEC[i][19:10]));
      chk($sformatf("R5 low div=%0d", VEC[i][29:20]), lo, 32'(VEC[i][9:0]));
    end

    // R7 divisor change held while running
    wr(mk(1'b1, 1'b0, 10'd4));
    wr(mk(1'b1, 1'b1, 10'd4));
    wr(mk(1'b1, 1'b1, 10'd6));
    chk("R7 readback", {22'd0, rd_data[15:6]}, 32'd6);
    measure(hi, lo);
    chk("R7 held high", hi, 2);
    chk("R7 held low", lo, 2);
    wr(mk(1'b1, 1'b0, 10'd6));
    wr(mk(1'b1, 1'b1, 10'd6));
    measure(hi, lo);
    chk("R7 applied high", hi, 3);
    chk("R7 applied low", lo, 3);

    // R6 bypass with divisor 1 and 0
    for (int d = 1; d >= 0; d--) begin
      wr(mk(1'b1, 1'b0, 10'(d)));
      wr(mk(1'b1, 1'b1, 10'(d)));
      repeat (2) @(negedge clk);
      n = 0;
      for (int i = 0; i < 4; i++) begin
        @(posedge clk); #1; if (card_clk !== 1'b1) n++;
        @(negedge clk);     if (card_clk !== 1'b0) n++;
      end
      chk($sformatf("R6 bypass div=%0d mismatches", d), n, 0);
    end

    // R4 and R3 with the internal clock off, then the stability gating
    wr(mk(1'b0, 1'b1, 10'd4));
    chk("R3 drop", {31'd0, rd_data[1]}, 32'd0);
    n = 0;
    for (int i = 0; i < 10; i++) begin @(negedge clk); if (card_clk !== 1'b0) n++; end
    chk("R4 ice=0 low", n, 0);
    wr(mk(1'b1, 1'b1, 10'd4));
    n = 0;
    for (int i = 0; i < STB; i++) begin
      if (card_clk !== 1'b0) n++;
      @(negedge clk);
    end
    chk("R4 low until stable", n, 0);

    // R8 command reset, a zero write does not cut it short
    wr(mk(1'b1, 1'b0, 10'd2) | (32'd1 << 25));
    n = (cmd_srst === 1'b1) ? 1 : 0;
    chk("R8 readback", {31'd0, rd_data[25]}, 32'd1);
    wr(mk(1'b1, 1'b0, 10'd2));
    if (cmd_srst === 1'b1) n++;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cmd_srst === 1'b1) n++; else break;
    end
    chk("R8 cmd high cycles", n, RSTC);
    wr(mk(1'b1, 1'b0, 10'd2) | (32'd1 << 26));
    chk("R8 data only", {30'd0, cmd_srst, dat_srst}, 32'd1);
    n = 1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (dat_srst === 1'b1) n++; else break;
    end
    chk("R8 data high cycles", n, RSTC);

    // R9 initialization stream
    wr(mk(1'b1, 1'b1, 10'd2));
    repeat (4) @(negedge clk);
    init_go = 1'b1;
    @(negedge clk);
    init_go = 1'b0;
    chk("R9 busy", {31'd0, init_busy}, 32'd1);
    prev = card_clk; rises = 0; seen_done = 1'b0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      if (card_clk === 1'b1 && prev === 1'b0) rises++;
      prev = card_clk;
      if (init_done === 1'b1) begin seen_done = 1'b1; break; end
    end
    chk("R9 done seen", {31'd0, seen_done}, 32'd1);
    chk("R9 rises", rises, INITC);
    chk("R9 busy cleared", {31'd0, init_busy}, 32'd0);
    @(negedge clk);
    chk("R9 done one cycle", {31'd0, init_done}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule